// File: doc/BRIEF.md
# Broadcast Descriptor Activation Controller

This block starts the transmission of broadcast message descriptors on behalf of up to 32 requesting agents. An agent posts an activation by writing its agent number together with a 6-bit set index. The block keeps one 2-bit status field per agent, packed into a readable status word. Accepted activations wait in a small first-in first-out queue and are serviced one at a time.

For each activation the block computes the address of the selected descriptor set from a programmable base register. It reads the first 64-byte descriptor from memory and hands it to the message sender. If the chaining flag in that descriptor is set, the next descriptor of the set follows as part of the same activation. Once the last descriptor is handed off, the block waits for the sender to report either completion or one of two timeout kinds, and records the result in the agent's status field.

Each set holds 8 descriptors of 64 bytes, so a set spans 512 bytes. Within a descriptor, bytes 0x00 to 0x1F hold the distribution vector, bytes 0x20 to 0x2F the payload and bytes 0x30 to 0x3F the header. The chaining flag is header bit 106, which is bit 490 of the descriptor word.

Top module: `bcast_act_ctrl`

## Requirements
- R1: An accepted activation write for agent k sets status bits [2k+1:2k] of `stat_word` to 1 (active) on the clock edge that takes the write.
- R2: The base register keeps `base_data` with its low 9 bits cleared. Descriptor d of set n is requested at base + n*512 + d*64, and `rd_req` is a one-cycle pulse.
- R3: The next descriptor of the set is fetched when bit 490 of the current descriptor (the chaining flag) is 1. The activation ends when that bit is 0 or after descriptor 7, whichever comes first.
- R4: Each returned descriptor appears on `snd_desc` with `snd_valid` high. Both are held unchanged until a cycle with `snd_ready` high, and that cycle hands the descriptor off.
- R5: After the last hand-off the agent stays active until the sender reports an outcome. `src_timeout` writes 3, otherwise `dst_timeout` writes 2, otherwise `done` writes 0.
- R6: A write for an agent whose field is 1 is ignored and raises `err` for one cycle, on the clock edge that follows the write.
- R7: Activations are serviced in the order of their writes. A write that arrives while the 4-entry queue is full is ignored, raises `err`, and leaves the agent's field unchanged.
- R8: After reset every status field is 0, and `rd_req`, `snd_valid` and `err` are 0.
- R9: `rd_req` and `snd_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr | input | 1 | Load the descriptor base register |
| base_data | input | AW | New base address |
| act_wr | input | 1 | Activation write strobe |
| act_agent | input | AGW | Requesting agent number |
| act_index | input | IDXW | Descriptor set index |
| err | output | 1 | Activation write rejected (one-cycle pulse) |
| stat_word | output | 2*2**AGW | Packed 2-bit status of all agents |
| rd_req | output | 1 | Descriptor read request pulse |
| rd_addr | output | AW | Descriptor read byte address |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | DW | Read response: one whole descriptor |
| snd_valid | output | 1 | Descriptor offered to the sender |
| snd_ready | input | 1 | Sender accepts the descriptor |
| snd_desc | output | DW | Descriptor handed to the sender |
| done | input | 1 | Sender finished the activation |
| dst_timeout | input | 1 | Sender reports a destination timeout |
| src_timeout | input | 1 | Sender reports a source timeout |

## Verification
A stale or wrong status field shows up on `stat_word` one cycle after the write or outcome that should have changed it. It also shows up as a wrongly accepted or rejected second write, with `err` in the following cycle. A broken address or chain counter shows up as a wrong `rd_addr`, or as a wrong number of handed-off descriptors, within the few cycles of one fetch round trip. A queue ordering fault becomes visible when descriptors leave in a set order that differs from the order of the writes.

// File: rtl/bda_pkg.sv
package bda_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DTO    = 2'd2,
    ST_STO    = 2'd3
  } act_code_t;
endpackage

// File: rtl/bda_fifo.sv
module bda_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [PW:0]   cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == (PW+1)'(DEPTH));
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/bda_status.sv
module bda_status
  import bda_pkg::*;
#(
  parameter int AGW = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    set_valid,
  input  logic [AGW-1:0]          set_agent,
  input  logic                    fin_valid,
  input  logic [AGW-1:0]          fin_agent,
  input  act_code_t               fin_code,
  output logic [2*(2**AGW)-1:0]   stat_word
);
  localparam int NAG = 2**AGW;

  for (genvar g = 0; g < NAG; g++) begin : g_fld
    act_code_t fld;
    always_ff @(posedge clk) begin
      if (rst)
        fld <= ST_IDLE;
      else if (fin_valid && fin_agent == AGW'(g))
        fld <= fin_code;
      else if (set_valid && set_agent == AGW'(g))
        fld <= ST_ACTIVE;
    end
    assign stat_word[2*g +: 2] = fld;
  end
endmodule

// File: rtl/bda_seq.sv
module bda_seq
  import bda_pkg::*;
#(
  parameter int AGW        = 5,
  parameter int IDXW       = 6,
  parameter int AW         = 32,
  parameter int DW         = 512,
  parameter int DPS        = 8,
  parameter int DESC_BYTES = 64,
  parameter int CHAIN_BIT  = 490
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   base,
  input  logic            q_empty,
  input  logic [AGW-1:0]  q_agent,
  input  logic [IDXW-1:0] q_index,
  output logic            q_pop,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic            rsp_valid,
  input  logic [DW-1:0]   rsp_data,
  output logic            snd_valid,
  input  logic            snd_ready,
  output logic [DW-1:0]   snd_desc,
  input  logic            done,
  input  logic            dto,
  input  logic            sto,
  output logic            fin_valid,
  output logic [AGW-1:0]  fin_agent,
  output act_code_t       fin_code
);
  localparam int SET_SH = $clog2(DPS * DESC_BYTES);
  localparam int DCW    = (DPS > 1) ? $clog2(DPS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SEND, S_WAIT} seq_t;

  seq_t           state;
  logic [DCW-1:0] dnum;
  logic [AGW-1:0] cur_agent;

  assign q_pop     = (state == S_IDLE) && !q_empty;
  assign fin_valid = (state == S_WAIT) && (done || dto || sto);
  assign fin_agent = cur_agent;
  assign fin_code  = sto ? ST_STO : (dto ? ST_DTO : ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      dnum      <= '0;
      cur_agent <= '0;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      snd_valid <= 1'b0;
      snd_desc  <= '0;
    end else begin
      rd_req <= 1'b0;
      case (state)
        S_IDLE: if (q_pop) begin
          cur_agent <= q_agent;
          dnum      <= '0;
          rd_addr   <= base + (AW'(q_index) << SET_SH);
          rd_req    <= 1'b1;
          state     <= S_FETCH;
        end
        S_FETCH: if (rsp_valid) begin
          snd_desc  <= rsp_data;
          snd_valid <= 1'b1;
          state     <= S_SEND;
        end
        S_SEND: if (snd_ready) begin
          snd_valid <= 1'b0;
          if (snd_desc[CHAIN_BIT] && dnum != DCW'(DPS-1)) begin
            dnum    <= dnum + 1'b1;
            rd_addr <= rd_addr + AW'(DESC_BYTES);
            rd_req  <= 1'b1;
            state   <= S_FETCH;
          end else begin
            state <= S_WAIT;
          end
        end
        S_WAIT: if (fin_valid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bcast_act_ctrl.sv
module bcast_act_ctrl
  import bda_pkg::*;
#(
  parameter int AGW        = 5,
  parameter int IDXW       = 6,
  parameter int AW         = 32,
  parameter int DW         = 512,
  parameter int DPS        = 8,
  parameter int DESC_BYTES = 64,
  parameter int FDEPTH     = 4,
  parameter int HDR_OFF    = 48,
  parameter int CHAIN_POS  = 106
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  base_wr,
  input  logic [AW-1:0]         base_data,
  input  logic                  act_wr,
  input  logic [AGW-1:0]        act_agent,
  input  logic [IDXW-1:0]       act_index,
  output logic                  err,
  output logic [2*(2**AGW)-1:0] stat_word,
  output logic                  rd_req,
  output logic [AW-1:0]         rd_addr,
  input  logic                  rsp_valid,
  input  logic [DW-1:0]         rsp_data,
  output logic                  snd_valid,
  input  logic                  snd_ready,
  output logic [DW-1:0]         snd_desc,
  input  logic                  done,
  input  logic                  dst_timeout,
  input  logic                  src_timeout
);
  localparam int SET_BYTES = DPS * DESC_BYTES;
  localparam int CHAIN_BIT = HDR_OFF * 8 + CHAIN_POS;
  localparam int QW        = AGW + IDXW;

  logic [AW-1:0]  base_q;
  logic           busy, accept;
  logic           q_empty, q_full, q_pop;
  logic [QW-1:0]  q_dout;
  logic           fin_valid;
  logic [AGW-1:0] fin_agent;
  act_code_t      fin_code;

  always_ff @(posedge clk) begin
    if (rst)          base_q <= '0;
    else if (base_wr) base_q <= base_data & ~AW'(SET_BYTES - 1);
  end

  assign busy   = (stat_word[{act_agent, 1'b0} +: 2] == ST_ACTIVE);
  assign accept = act_wr && !busy && !q_full;

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= act_wr && (busy || q_full);
  end

  bda_fifo #(.W(QW), .DEPTH(FDEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(accept), .din({act_agent, act_index}),
    .pop(q_pop), .dout(q_dout),
    .empty(q_empty), .full(q_full)
  );

  bda_seq #(
    .AGW(AGW), .IDXW(IDXW), .AW(AW), .DW(DW),
    .DPS(DPS), .DESC_BYTES(DESC_BYTES), .CHAIN_BIT(CHAIN_BIT)
  ) u_seq (
    .clk(clk), .rst(rst), .base(base_q),
    .q_empty(q_empty), .q_agent(q_dout[QW-1:IDXW]), .q_index(q_dout[IDXW-1:0]),
    .q_pop(q_pop),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_desc(snd_desc),
    .done(done), .dto(dst_timeout), .sto(src_timeout),
    .fin_valid(fin_valid), .fin_agent(fin_agent), .fin_code(fin_code)
  );

  bda_status #(.AGW(AGW)) u_stat (
    .clk(clk), .rst(rst),
    .set_valid(accept), .set_agent(act_agent),
    .fin_valid(fin_valid), .fin_agent(fin_agent), .fin_code(fin_code),
    .stat_word(stat_word)
  );
endmodule

// File: rtl/bda_checker.sv
module bda_checker #(
  parameter int AGW = 5,
  parameter int AW  = 32,
  parameter int DW  = 512
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  act_wr,
  input logic [AGW-1:0]        act_agent,
  input logic [2*(2**AGW)-1:0] stat_word,
  input logic                  err,
  input logic                  rd_req,
  input logic [AW-1:0]         rd_addr,
  input logic                  snd_valid,
  input logic                  snd_ready,
  input logic [DW-1:0]         snd_desc
);
  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  assert_req_align_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_addr[5:0] == 6'd0));

  assert_hold_desc_R4: assert property (@(posedge clk) disable iff (rst)
    (snd_valid && !snd_ready) |=> (snd_valid && $stable(snd_desc)));

  assert_busy_reject_R6: assert property (@(posedge clk) disable iff (rst)
    (act_wr && stat_word[{act_agent, 1'b0} +: 2] == 2'd1) |=> err);

  assert_req_send_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_req, snd_valid}));
endmodule

bind bcast_act_ctrl bda_checker #(.AGW(AGW), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .act_wr(act_wr), .act_agent(act_agent),
  .stat_word(stat_word), .err(err), .rd_req(rd_req), .rd_addr(rd_addr),
  .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_desc(snd_desc)
);

// File: tb/bcast_act_ctrl_test.sv
`timescale 1ns/1ps
module bcast_act_ctrl_test;
  localparam int AGW = 5, IDXW = 6, AW = 32, DW = 512;
  localparam int NAG = 32;
  localparam logic [31:0] BASE_RAW = 32'h0001_0123;
  localparam logic [31:0] BASE     = 32'h0001_0000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic base_wr = 0; logic [AW-1:0] base_data = '0;
  logic act_wr = 0; logic [AGW-1:0] act_agent = '0; logic [IDXW-1:0] act_index = '0;
  logic err; logic [2*NAG-1:0] stat_word;
  logic rd_req; logic [AW-1:0] rd_addr;
  logic rsp_valid = 0; logic [DW-1:0] rsp_data = '0;
  logic snd_valid; logic snd_ready = 1'b1; logic [DW-1:0] snd_desc;
  logic done = 0, dst_timeout = 0, src_timeout = 0;

  bcast_act_ctrl uut (
    .clk(clk), .rst(rst), .base_wr(base_wr), .base_data(base_data),
    .act_wr(act_wr), .act_agent(act_agent), .act_index(act_index),
    .err(err), .stat_word(stat_word), .rd_req(rd_req), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_desc(snd_desc),
    .done(done), .dst_timeout(dst_timeout), .src_timeout(src_timeout)
  );

  int checks = 0, errors = 0;
  logic all_chain = 1'b0;

  // memory model: two-cycle response, chaining flag computed from address
  logic pend = 0; logic [AW-1:0] pend_addr = '0;
  function automatic logic [DW-1:0] mk_desc(input logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    int set_n = int'(((a - BASE) >> 9) & 32'd63);
    int d     = int'((a >> 6) & 32'd7);
    v[31:0] = a;
    v[490]  = all_chain ? 1'b1 : (d < (set_n % 8));
    return v;
  endfunction
  always @(posedge clk) begin
    rsp_valid <= pend;
    rsp_data  <= mk_desc(pend_addr);
    pend      <= rd_req;
    pend_addr <= rd_addr;
  end

  // sender log
  logic [31:0] log_addr [256];
  int log_n = 0;
  always @(posedge clk) begin
    if (snd_valid && snd_ready) begin
      log_addr[log_n % 256] <= snd_desc[31:0];
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fld(input int k);
    return stat_word[2*k +: 2];
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic prog_base(input logic [AW-1:0] b);
    @(negedge clk); base_wr = 1'b1; base_data = b;
    @(negedge clk); base_wr = 1'b0;
  endtask

  task automatic do_write(input int agent, input int idx);
    @(negedge clk); act_wr = 1'b1; act_agent = AGW'(agent); act_index = IDXW'(idx);
    @(negedge clk); act_wr = 1'b0;
  endtask

  task automatic wait_log(input int target);
    for (int t = 0; t < 300 && log_n < target; t++) @(negedge clk);
  endtask

  // outcome o: 0 done, 1 dst, 2 src, 3 dst+src, 4 done+dst
  task automatic outcome(input int o);
    @(negedge clk);
    done        = (o == 0) || (o == 4);
    dst_timeout = (o == 1) || (o == 3) || (o == 4);
    src_timeout = (o == 2) || (o == 3);
    @(negedge clk);
    done = 0; dst_timeout = 0; src_timeout = 0;
  endtask

  function automatic logic [1:0] exp_code(input int o);
    case (o)
      0: return 2'd0;
      1: return 2'd2;
      2: return 2'd3;
      3: return 2'd3;
      default: return 2'd2;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int start, n, agent;
    int idxs[6];
    logic errs[6];
    do_reset();
    @(negedge clk);
    // R8: reset state
    chk(stat_word == '0, "R8 status", longint'(stat_word), 0);
    chk(rd_req == 0,    "R8 rd_req", longint'(rd_req), 0);
    chk(snd_valid == 0, "R8 snd_valid", longint'(snd_valid), 0);
    chk(err == 0,       "R8 err", longint'(err), 0);

    prog_base(BASE_RAW);

    // sweep of every set index
    for (int idx = 0; idx < 64; idx++) begin
      agent = idx % NAG;
      n = idx % 8 + 1;
      start = log_n;
      do_write(agent, idx);
      chk(err == 0,     "R1 accept err", longint'(err), 0);
      chk(fld(agent) == 2'd1, "R1 field active", longint'(fld(agent)), 1);
      do_write(agent, (idx + 1) % 64);   // R6: busy agent
      chk(err == 1,     "R6 busy err", longint'(err), 1);
      @(negedge clk);
      chk(err == 0,     "R6 err one cycle", longint'(err), 0);
      wait_log(start + n);
      for (int d = 0; d < n; d++)
        chk(log_addr[(start + d) % 256] == BASE + 32'(idx * 512 + d * 64),
            "R2 R3 address", longint'(log_addr[(start + d) % 256]),
            longint'(BASE + 32'(idx * 512 + d * 64)));
      repeat (6) @(negedge clk);
      chk(log_n == start + n, "R3 descriptor count", longint'(log_n - start), longint'(n));
      chk(fld(agent) == 2'd1, "R5 active until outcome", longint'(fld(agent)), 1);
      outcome(idx % 5);
      chk(fld(agent) == exp_code(idx % 5), "R5 outcome code",
          longint'(fld(agent)), longint'(exp_code(idx % 5)));
      repeat (8) @(negedge clk);
      chk(log_n == start + n, "R6 ignored write sent nothing", longint'(log_n - start), longint'(n));
    end

    // R3: chain set on every descriptor stops after descriptor 7
    all_chain = 1'b1;
    start = log_n;
    do_write(3, 5);
    wait_log(start + 8);
    repeat (10) @(negedge clk);
    chk(log_n == start + 8, "R3 limit eight", longint'(log_n - start), 8);
    chk(log_addr[(start + 7) % 256] == BASE + 32'(5 * 512 + 7 * 64), "R3 last address",
        longint'(log_addr[(start + 7) % 256]), longint'(BASE + 32'(5 * 512 + 7 * 64)));
    outcome(0);
    all_chain = 1'b0;

    // R4 / R7: stalled sender, queue fill, ordering
    do_reset();
    prog_base(BASE_RAW);
    snd_ready = 1'b0;
    start = log_n;
    for (int k = 0; k < 6; k++) idxs[k] = 8 * k;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k > 0) errs[k-1] = err;
      act_wr = 1'b1; act_agent = AGW'(k); act_index = IDXW'(idxs[k]);
    end
    @(negedge clk);
    errs[5] = err;
    act_wr = 1'b0;
    for (int k = 0; k < 6; k++)
      chk(errs[k] == (k == 5), "R7 full reject", longint'(errs[k]), longint'(k == 5));
    chk(fld(5) == 2'd0, "R7 rejected field unchanged", longint'(fld(5)), 0);
    for (int k = 0; k < 5; k++)
      chk(fld(k) == 2'd1, "R1 queued active", longint'(fld(k)), 1);
    repeat (10) @(negedge clk);
    chk(log_n == start, "R4 no handoff while stalled", longint'(log_n - start), 0);
    chk(snd_valid == 1, "R4 held valid", longint'(snd_valid), 1);
    chk(snd_desc[31:0] == BASE, "R4 held desc", longint'(snd_desc[31:0]), longint'(BASE));
    snd_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      wait_log(start + k + 1);
      chk(log_addr[(start + k) % 256] == BASE + 32'(idxs[k] * 512), "R7 order",
          longint'(log_addr[(start + k) % 256]), longint'(BASE + 32'(idxs[k] * 512)));
      outcome(0);
      chk(fld(k) == 2'd0, "R5 done idle", longint'(fld(k)), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule